// File: doc/BRIEF.md
# Oversampled Serial Bit Recovery

This block recovers data bits from a serial line that carries no clock. A local sample clock runs at an odd integer multiple `OSR` of the nominal bit rate. The raw line passes through a synchronizer chain. Every level change seen at the end of that chain restarts a phase counter. The counter selects one sample per bit, `(OSR-1)/2` counts after the restart, so the sampling point sits an equal distance from the edge behind it and the edge ahead of it. That keeps it as far as possible from any transition.

If no transition arrives, the counter wraps every `OSR` sample clocks and goes on recovering bits. Each recovered bit appears on `data_o` together with a single-cycle enable on `strobe_o`, which serves as the recovered clock. A counter tracks how many bits have been captured since the last transition. Once that count exceeds `MAX_CID`, `loss_o` warns that the phase can no longer be trusted. The flag clears when the next transition is seen.

Top module: `os_cdr`

## Requirements
- R1: While `rst_ni` is low, `data_o`, `strobe_o` and `loss_o` are all 0 (asynchronous reset).
- R2: `strobe_o` is never high for two consecutive sample clocks.
- R3: A level change on `line_i` that is first seen at a rising edge produces the strobe for the new bit at the `SYNC_STAGES+1+(OSR-1)/2`-th rising edge after it. With the defaults this is the 5th edge. `data_o` then holds the new level.
- R4: A stream whose bit period is exactly `OSR` sample clocks is recovered without error, whatever the run lengths.
- R5: A stream whose bit period is `OSR-1` or `OSR+1` sample clocks, with runs of at most two identical bits, is recovered without error.
- R6: While no transition occurs, two consecutive strobes are exactly `OSR` sample clocks apart, and `data_o` keeps its value.
- R7: At each strobe, `loss_o` is 1 exactly when the number of strobes since the last detected transition exceeds `MAX_CID`. Before any transition, the count runs from reset. `loss_o` can rise only together with a strobe.
- R8: A transition clears `loss_o` at the `SYNC_STAGES+1`-th rising edge after the change is first sampled. Until then the flag keeps its value.
- R9: `data_o` changes only in a cycle where `strobe_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, `OSR` times the nominal bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw serial line, asynchronous to `clk_i` |
| data_o | output | 1 | Last recovered bit |
| strobe_o | output | 1 | One-cycle enable marking a new bit on `data_o` |
| loss_o | output | 1 | Run without transitions is longer than `MAX_CID` bits |

## Verification
The assertion that ties a falling `loss_o` to a line change a fixed number of cycles earlier relies on two conditions. First, `line_i` is clean, with no glitches shorter than a sample clock. Second, the line is low when reset is released, so the synchronizer does not report a spurious edge. The stimulus changes `line_i` only 2 ns after a rising edge, with bit periods of at least `OSR-1` clocks. It keeps the line low through every reset.

Drift-prone runs are limited to two bits whenever the bit period is off the nominal rate. Long constant runs are driven only at the exact rate, where the wrapping counter stays centred.

// File: rtl/os_cdr_pkg.sv
package os_cdr_pkg;
  typedef struct packed {
    logic level;  // synchronized line value
    logic edge_;  // level differs from previous sample
  } line_evt_t;
endpackage

// File: rtl/os_line_sync.sv
module os_line_sync #(
  parameter int STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_i,
  output os_cdr_pkg::line_evt_t evt_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= line_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign evt_o.level = chain_q[STAGES-1];
  assign evt_o.edge_ = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/os_phase_ctr.sv
module os_phase_ctr #(
  parameter int OSR = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic capt_o
);
  localparam int PW   = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int LAST = OSR - 1;
  localparam int MID  = (OSR - 1) / 2;

  logic [PW-1:0] phase_q, phase_d;

  // edge sample is position 0 of the new bit
  always_comb begin
    if (edge_i)                          phase_d = '0;
    else if (phase_q == PW'(LAST))       phase_d = '0;
    else                                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) phase_q <= PW'(LAST);
    else         phase_q <= phase_d;

  assign capt_o = (phase_d == PW'(MID));
endmodule

// File: rtl/os_cid_mon.sv
module os_cid_mon #(
  parameter int MAX_CID = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic capt_i,
  output logic loss_o
);
  localparam int TOP = MAX_CID + 1;
  localparam int CW  = $clog2(TOP + 1);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (edge_i)                          run_d = '0;
    else if (capt_i && run_q != CW'(TOP)) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run_q  <= '0;
      loss_o <= 1'b0;
    end else begin
      run_q  <= run_d;
      loss_o <= (run_d > CW'(MAX_CID));
    end
endmodule

// File: rtl/os_cdr.sv
module os_cdr #(
  parameter int OSR         = 5,
  parameter int MAX_CID     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic data_o,
  output logic strobe_o,
  output logic loss_o
);
  os_cdr_pkg::line_evt_t evt;
  logic capt;

  os_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .evt_o (evt)
  );

  os_phase_ctr #(.OSR(OSR)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(evt.edge_),
    .capt_o(capt)
  );

  os_cid_mon #(.MAX_CID(MAX_CID)) u_cid (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(evt.edge_),
    .capt_i(capt),
    .loss_o(loss_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      data_o   <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= capt;
      if (capt) data_o <= evt.level;
    end
endmodule

// File: rtl/os_cdr_chk.sv
module os_cdr_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic data_o,
  input logic strobe_o,
  input logic loss_o
);
  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(data_o));

  // R7
  loss_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_o) |-> strobe_o);

  // R8
  loss_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(loss_o) |-> ($past(line_i, SYNC_STAGES + 1) != $past(line_i, SYNC_STAGES + 2)));

  // R1
  always @(negedge clk_i)
    if (!rst_ni) reset_clear_chk: assert (!data_o && !strobe_o && !loss_o);
endmodule

bind os_cdr os_cdr_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .line_i  (line_i),
  .data_o  (data_o),
  .strobe_o(strobe_o),
  .loss_o  (loss_o)
);

// File: tb/os_cdr_test.sv
`timescale 1ns/1ps
module os_cdr_test;
  localparam int OSR     = 5;
  localparam int MAX_CID = 5;
  localparam int SYNC    = 2;
  localparam int MID     = (OSR - 1) / 2;
  localparam int STB_DLY = SYNC + 1 + MID;  // negedge ticks from first sight of change to strobe
  localparam int NBITS   = 64;

  logic clk = 1'b0, rst_ni = 1'b0, line_i = 1'b0;
  logic data_o, strobe_o, loss_o;

  os_cdr #(.OSR(OSR), .MAX_CID(MAX_CID), .SYNC_STAGES(SYNC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i),
    .data_o(data_o), .strobe_o(strobe_o), .loss_o(loss_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int tick, since_chg, run, n_str, last_tick;
  logic line_seen, last_d;
  bit chg_mark[int];
  logic rx_q[$];
  logic tx_q[$];
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    tick++;
    if (line_i !== line_seen) begin
      line_seen = line_i;
      since_chg = 1;
      chg_mark[tick] = 1'b1;
    end else since_chg++;
    if (strobe_o) begin
      if (n_str > 0 && data_o == last_d) begin
        run++;
        check(tick - last_tick == OSR, "R6 strobe spacing", tick - last_tick, OSR);
      end else begin
        run = 1;
        if (n_str > 0 || data_o)
          check(chg_mark.exists(tick - STB_DLY), "R3 strobe latency", tick, STB_DLY);
      end
      check(loss_o == (run > MAX_CID), "R7 loss at strobe", loss_o, run > MAX_CID);
      rx_q.push_back(data_o);
      last_d = data_o; last_tick = tick; n_str++;
    end
    if (since_chg == SYNC + 1)
      check(loss_o == (run > MAX_CID), "R8 loss held", loss_o, run > MAX_CID);
    if (since_chg == SYNC + 2)
      check(loss_o == 1'b0, "R8 loss cleared", loss_o, 0);
  end

  task automatic do_reset();
    @(posedge clk); #2;
    rst_ni = 1'b0; line_i = 1'b0;
    @(negedge clk);
    // R1
    check(data_o == 0 && strobe_o == 0 && loss_o == 0, "R1 reset state",
          {data_o, strobe_o, loss_o}, 0);
    tick = 0; since_chg = 1000; run = 0; n_str = 0; last_tick = 0;
    line_seen = 1'b0; last_d = 1'b0;
    chg_mark.delete(); rx_q.delete(); tx_q.delete();
    @(posedge clk); #2;
    rst_ni = 1'b1;
  endtask

  function automatic logic next_bit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  // kind 0: random, runs <= maxrun; kind 1: runs of 1..9; kind 2: alternating
  task automatic run_frame(input int per, input int kind, input int maxrun, input string req);
    int r;
    logic b;
    do_reset();
    repeat (8 * OSR) @(posedge clk);
    #2;
    if (kind == 1) begin
      b = 1'b1;
      for (int len = 1; len <= 9; len++) begin
        for (int k = 0; k < len; k++) tx_q.push_back(b);
        b = ~b;
      end
    end else begin
      tx_q.push_back(1'b1); r = 1;
      for (int i = 1; i < NBITS; i++) begin
        b = (kind == 2) ? ~tx_q[i-1] : next_bit();
        if (b == tx_q[i-1]) begin
          if (r >= maxrun) begin b = ~b; r = 1; end else r++;
        end else r = 1;
        tx_q.push_back(b);
      end
    end
    foreach (tx_q[i]) begin
      line_i = tx_q[i];
      repeat (per) @(posedge clk);
      #2;
    end
    repeat (8 * OSR) @(posedge clk);
    while (rx_q.size() > 0 && rx_q[0] == 1'b0) void'(rx_q.pop_front());
    check(rx_q.size() >= tx_q.size(), {req, " bit count"}, rx_q.size(), tx_q.size());
    foreach (tx_q[i])
      if (i < rx_q.size())
        check(rx_q[i] == tx_q[i], {req, " recovered bit"}, rx_q[i], tx_q[i]);
  endtask

  bit done = 0;

  initial begin
    run_frame(OSR,     2, 1,    "R4 alternating");
    run_frame(OSR,     0, 8,    "R4 random long runs");
    run_frame(OSR,     1, 9,    "R4 R7 graded runs");
    run_frame(OSR - 1, 0, 2,    "R5 fast");
    run_frame(OSR + 1, 0, 2,    "R5 slow");
    run_frame(OSR - 1, 2, 1,    "R5 fast alternating");
    run_frame(OSR + 1, 2, 1,    "R5 slow alternating");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule